// File: doc/BRIEF.md
# Paged PHY Register File

This block is the small register file that a physical-layer device exposes to its link-layer controller. The link side reaches it through a single request strobe with a 4-bit address, a write flag and 8-bit write data. The lower eight addresses form a fixed base set. The upper eight addresses form a window onto one of several pages. The page is chosen by a field in base address 7. Page 0 shows the status of one port, picked by a port-select field in the same register. Page 7 is a vendor page that holds a link-speed control and a 24-bit product identifier. Every other page reads as zero.

Several base fields are fixed capabilities that take their values from strap pins. A two-port strap sets the reported port count. Three configuration straps appear in a capability register. The block sees two reset events. Hardware reset (`rst_n`) clears everything. Bus reset (`bus_rst`) clears only the fields that must be rebuilt after the bus is reconfigured. Selection and vendor settings keep their values across a bus reset. The peer-speed view stays hidden after any reset until self-identification reports that it is complete.

Top module: `phy_paged_regfile`

## Requirements
- R1: Address 0 reads `{3'b111, 1'b0, count[3:0]}`, where count is the number of ports: 2 when `two_port` is 1 and 1 when it is 0. So it reads 8'hE2 or 8'hE1.
- R2: Address 1 reads `{cfg_strap[2:0], 2'b00, 3'b010}`. Writes to addresses 0 and 1 have no effect on what they read.
- R3: `rd_valid` is high in exactly the cycle after a read strobe (`req_valid`=1, `req_write`=0), with `rd_data` valid in that cycle. It is low after writes and after idle cycles. Both outputs are 0 after hardware reset.
- R4: Address 7 is read/write. Bits [7:5] hold the page select and bits [4:0] hold the port select. Hardware reset clears both. Bus reset leaves both unchanged.
- R5: Address 2 is an 8-bit read/write control register. Both hardware reset and bus reset clear it to 0, and bus reset wins over a write made in the same cycle.
- R6: With page 0 selected, address 8 reads `{4'b0, port_stat}` of the selected port, and address 9 reads `{5'b0, peer speed}` of the selected port. Port n uses `port_stat[4n+3:4n]` and `peer_spd[3n+2:3n]`.
- R7: The peer-speed field reads 0 after hardware reset or bus reset until a `selfid_done` pulse arrives. When `bus_rst` and `selfid_done` are high in the same cycle, the field stays hidden.
- R8: A peer speed above 3'b010 is reported as 3'b010.
- R9: If the port select is not below the port count from R1, the page-0 registers read 0.
- R10: With page 7 selected, address 8 bits [1:0] are a read/write link-speed field and bits [7:2] read 0. Hardware reset sets the field to 2'b10. Bus reset does not change it.
- R11: With page 7 selected, addresses 13, 14 and 15 read the product identifier bytes from most to least significant. Writes to them are ignored.
- R12: The following addresses read 0: 3 to 6, page 0 addresses 10 to 15, page 7 addresses 9 to 12, and every address of pages 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| bus_rst | input | 1 | Bus reset pulse, one cycle |
| selfid_done | input | 1 | Self-identification complete pulse |
| two_port | input | 1 | Strap: 1 for two ports, 0 for one |
| cfg_strap | input | 3 | Configuration straps shown at address 1 |
| port_stat | input | PORTS*4 | Per-port status bits, port 0 in the low nibble |
| peer_spd | input | PORTS*3 | Per-port raw peer speed codes |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The bench targets the fields that separate the two resets. It changes the port select, the page, the control register and the link speed, then raises a bus reset. A design that cleared selection on bus reset would lose the selected page, and one that kept the control register would read back stale data. It reads peer speed before and after self-identification, and with bus reset and self-identification in the same cycle. This catches a speed leaked early, or a set that wins over a clear. It flips the two-port strap and selects out-of-range ports, which catches a wrong count or a status leaked from a missing port. It writes read-only capability and identifier bytes and reads back unmapped pages, which catches writable constants or a page decode that aliases.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int PSEL_W = 5;
    localparam int PAGE_W = 3;
    localparam int SPD_W  = 3;

    localparam logic [ADDR_W-1:0] A_IDENT  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CAPS   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SELECT = 4'd7;
    localparam logic [ADDR_W-1:0] A_WIN0   = 4'd8;
    localparam logic [ADDR_W-1:0] A_WIN1   = 4'd9;

    localparam logic [PAGE_W-1:0] PG_PORT   = 3'd0;
    localparam logic [PAGE_W-1:0] PG_VENDOR = 3'd7;

    localparam logic [SPD_W-1:0] SPD_TOP = 3'b010;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [PSEL_W-1:0] port;
        logic [DATA_W-1:0] ctrl;
        logic              spd_ok;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } core_t;
endpackage

// File: rtl/phyreg_port_view.sv
module phyreg_port_view
    import phyreg_pkg::*;
#(
    parameter int PORTS  = 2,
    parameter int STAT_W = 4
) (
    input  logic [PSEL_W-1:0]       port_sel,
    input  logic                    two_port,
    input  logic                    spd_ok,
    input  logic [PORTS*STAT_W-1:0] port_stat,
    input  logic [PORTS*SPD_W-1:0]  peer_spd,
    output logic [STAT_W-1:0]       stat_o,
    output logic [SPD_W-1:0]        spd_o,
    output logic                    present
);
    localparam logic [PSEL_W-1:0] PORTS_W = PSEL_W'(PORTS);

    logic [STAT_W-1:0] stat_a [PORTS];
    logic [SPD_W-1:0]  spd_a  [PORTS];
    logic [STAT_W-1:0] stat_raw;
    logic [SPD_W-1:0]  spd_raw;
    logic [PSEL_W-1:0] count;

    for (genvar i = 0; i < PORTS; i++) begin : g_split
        assign stat_a[i] = port_stat[i*STAT_W +: STAT_W];
        assign spd_a[i]  = peer_spd[i*SPD_W +: SPD_W];
    end

    always_comb begin
        stat_raw = '0;
        spd_raw  = '0;
        for (int i = 0; i < PORTS; i++) begin
            if (port_sel == PSEL_W'(i)) begin
                stat_raw = stat_a[i];
                spd_raw  = spd_a[i];
            end
        end
    end

    assign count   = two_port ? PORTS_W : PSEL_W'(1);
    assign present = port_sel < count;

    always_comb begin
        stat_o = present ? stat_raw : '0;
        if (!present || !spd_ok) begin
            spd_o = '0;
        end else if (spd_raw > SPD_TOP) begin
            spd_o = SPD_TOP;
        end else begin
            spd_o = spd_raw;
        end
    end
endmodule

// File: rtl/phyreg_vendor_page.sv
module phyreg_vendor_page
    import phyreg_pkg::*;
#(
    parameter logic [23:0] PRODUCT_ID = 24'h3CA571
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_off,
    input  logic [1:0]        wr_lspd,
    input  logic [2:0]        rd_off,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [1:0] LSPD_RST = 2'b10;

    logic [1:0] lspd_d, lspd_q;

    always_comb begin
        lspd_d = lspd_q;
        if (wr_en && wr_off == 3'd0) begin
            lspd_d = wr_lspd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lspd_q <= LSPD_RST;
        end else begin
            lspd_q <= lspd_d;
        end
    end

    always_comb begin
        case (rd_off)
            3'd0:    rd_val = {6'b0, lspd_q};
            3'd5:    rd_val = PRODUCT_ID[23:16];
            3'd6:    rd_val = PRODUCT_ID[15:8];
            3'd7:    rd_val = PRODUCT_ID[7:0];
            default: rd_val = '0;
        endcase
    end

    // R10: bus reset must not disturb the link speed
    p_lspd_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && !wr_en) |=> $stable(lspd_q));
endmodule

// File: rtl/phy_paged_regfile.sv
module phy_paged_regfile
    import phyreg_pkg::*;
#(
    parameter int          PORTS      = 2,
    parameter int          STAT_W     = 4,
    parameter logic [23:0] PRODUCT_ID = 24'h3CA571
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_rst,
    input  logic                    selfid_done,
    input  logic                    two_port,
    input  logic [2:0]              cfg_strap,
    input  logic [PORTS*STAT_W-1:0] port_stat,
    input  logic [PORTS*SPD_W-1:0]  peer_spd,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data
);
    core_t d, q;

    logic              wr_stb, rd_stb;
    logic [STAT_W-1:0] pv_stat;
    logic [SPD_W-1:0]  pv_spd;
    logic              pv_present;
    logic [DATA_W-1:0] vnd_val;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] win_val;
    logic              vnd_wr;

    assign wr_stb = req_valid && req_write;
    assign rd_stb = req_valid && !req_write;
    assign vnd_wr = wr_stb && req_addr[3] && (q.page == PG_VENDOR);

    phyreg_port_view #(
        .PORTS (PORTS),
        .STAT_W(STAT_W)
    ) u_port_view (
        .port_sel (q.port),
        .two_port (two_port),
        .spd_ok   (q.spd_ok),
        .port_stat(port_stat),
        .peer_spd (peer_spd),
        .stat_o   (pv_stat),
        .spd_o    (pv_spd),
        .present  (pv_present)
    );

    phyreg_vendor_page #(
        .PRODUCT_ID(PRODUCT_ID)
    ) u_vendor (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_rst(bus_rst),
        .wr_en  (vnd_wr),
        .wr_off (req_addr[2:0]),
        .wr_lspd(req_wdata[1:0]),
        .rd_off (req_addr[2:0]),
        .rd_val (vnd_val)
    );

    // paged window decode
    always_comb begin
        win_val = '0;
        if (q.page == PG_PORT) begin
            if (req_addr == A_WIN0) begin
                win_val = DATA_W'(pv_stat);
            end else if (req_addr == A_WIN1) begin
                win_val = DATA_W'(pv_spd);
            end
        end else if (q.page == PG_VENDOR) begin
            win_val = vnd_val;
        end
    end

    // base decode
    always_comb begin
        if (req_addr[3]) begin
            rd_mux = win_val;
        end else begin
            case (req_addr)
                A_IDENT:  rd_mux = {3'b111, 1'b0, two_port ? 4'(PORTS) : 4'd1};
                A_CAPS:   rd_mux = {cfg_strap, 2'b00, SPD_TOP};
                A_CTRL:   rd_mux = q.ctrl;
                A_SELECT: rd_mux = {q.page, q.port};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        d = q;
        if (wr_stb && req_addr == A_SELECT) begin
            d.page = req_wdata[7:5];
            d.port = req_wdata[4:0];
        end
        if (wr_stb && req_addr == A_CTRL) begin
            d.ctrl = req_wdata;
        end
        if (selfid_done) begin
            d.spd_ok = 1'b1;
        end
        if (bus_rst) begin
            d.ctrl   = '0;
            d.spd_ok = 1'b0;
        end
        d.rvalid = rd_stb;
        if (rd_stb) begin
            d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_valid = q.rvalid;
    assign rd_data  = q.rdata;

    // R3: one valid pulse per read, none otherwise
    p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    p_rd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    // R1: identity byte always carries the extended-set code
    p_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && req_addr == A_IDENT) |=> (rd_data[7:5] == 3'b111));

    // R4: selection survives a bus reset
    p_sel_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && !(wr_stb && req_addr == A_SELECT)) |=> $stable({q.page, q.port}));

    // R5: control register cleared by bus reset
    p_ctrl_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (q.ctrl == '0));

    // R7: peer speed hidden right after a bus reset
    p_spd_hide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !q.spd_ok);

    // R8: reported peer speed never exceeds the top code
    p_spd_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && req_addr == A_WIN1 && q.page == PG_PORT) |=> (rd_data[2:0] <= SPD_TOP));
endmodule

// File: tb/tb_phy_paged_regfile.sv
module tb_phy_paged_regfile;
    localparam logic [23:0] PID = 24'h3CA571;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       selfid_done = 1'b0;
    logic       two_port = 1'b1;
    logic [2:0] cfg_strap = 3'b101;
    logic [7:0] port_stat = 8'h5A;
    logic [5:0] peer_spd = {3'b111, 3'b001};
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = 4'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    phy_paged_regfile #(.PORTS(2), .STAT_W(4), .PRODUCT_ID(PID)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .selfid_done(selfid_done),
        .two_port(two_port), .cfg_strap(cfg_strap), .port_stat(port_stat),
        .peer_spd(peer_spd), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare every valid read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R3 actual=unexpected_valid expected=no_valid data=%h", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse(input bit br, input bit sd);
        @(negedge clk);
        bus_rst = br; selfid_done = sd;
        @(negedge clk);
        bus_rst = 1'b0; selfid_done = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3 actual=%0d pending expected=0 pending", exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset rd_valid", {7'b0, rd_valid}, 8'h00);
        check("R3 reset rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        rd(4'd0, 8'hE2, "R1 two ports");
        rd(4'd1, 8'hA2, "R2 caps");
        wr(4'd0, 8'hFF);
        rd(4'd0, 8'hE2, "R2 ident write ignored");
        wr(4'd1, 8'h00);
        rd(4'd1, 8'hA2, "R2 caps write ignored");
        rd(4'd7, 8'h00, "R4 select after reset");
        rd(4'd2, 8'h00, "R5 ctrl after reset");
        wr(4'd2, 8'h5C);
        rd(4'd2, 8'h5C, "R5 ctrl write");

        rd(4'd8, 8'h0A, "R6 port0 status");
        rd(4'd9, 8'h00, "R7 speed hidden before selfid");
        pulse(1'b0, 1'b1);
        rd(4'd9, 8'h01, "R6 port0 speed");
        wr(4'd7, 8'h01);
        rd(4'd7, 8'h01, "R4 select readback");
        rd(4'd8, 8'h05, "R6 port1 status");
        rd(4'd9, 8'h02, "R8 speed clamp");
        rd(4'd10, 8'h00, "R12 page0 addr10");
        rd(4'd3, 8'h00, "R12 addr3");

        wr(4'd7, 8'h13);
        rd(4'd7, 8'h13, "R4 select full field");
        rd(4'd8, 8'h00, "R9 port19 status");
        rd(4'd9, 8'h00, "R9 port19 speed");
        wr(4'd7, 8'h01);
        two_port = 1'b0;
        rd(4'd0, 8'hE1, "R1 one port");
        rd(4'd8, 8'h00, "R9 port1 absent");
        two_port = 1'b1;

        pulse(1'b1, 1'b0);
        rd(4'd7, 8'h01, "R4 kept across bus reset");
        rd(4'd2, 8'h00, "R5 ctrl cleared by bus reset");
        rd(4'd9, 8'h00, "R7 speed hidden after bus reset");
        pulse(1'b0, 1'b1);
        rd(4'd9, 8'h02, "R7 speed back after selfid");
        pulse(1'b1, 1'b1);
        rd(4'd9, 8'h00, "R7 bus reset beats selfid");

        wr(4'd7, 8'hE0);
        rd(4'd8, 8'h02, "R10 link speed reset value");
        rd(4'd13, PID[23:16], "R11 id msb");
        rd(4'd14, PID[15:8], "R11 id mid");
        rd(4'd15, PID[7:0], "R11 id lsb");
        wr(4'd13, 8'h00);
        rd(4'd13, PID[23:16], "R11 id write ignored");
        rd(4'd12, 8'h00, "R12 vendor addr12");
        wr(4'd8, 8'hFD);
        rd(4'd8, 8'h01, "R10 link speed write");
        pulse(1'b1, 1'b0);
        rd(4'd8, 8'h01, "R10 link speed kept on bus reset");
        rd(4'd7, 8'hE0, "R4 vendor page kept");

        wr(4'd2, 8'h77);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd2; req_wdata = 8'h33;
        bus_rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; bus_rst = 1'b0;
        rd(4'd2, 8'h00, "R5 bus reset beats write");

        wr(4'd7, 8'h40);
        rd(4'd8, 8'h00, "R12 page2 addr8");
        rd(4'd13, 8'h00, "R12 page2 addr13");
        drain();

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'd7, 8'h00, "R4 cleared by hw reset");
        rd(4'd2, 8'h00, "R5 cleared by hw reset");
        rd(4'd9, 8'h00, "R7 speed hidden after hw reset");
        wr(4'd7, 8'hE0);
        rd(4'd8, 8'h02, "R10 link speed hw reset");
        drain();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule